// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns the virtual address of an instruction fetch into a physical address in the same cycle. It holds a small fully associative table of page translations. Each table entry is tagged by virtual page number and address space number, and carries a page frame number and one execute-enable bit per privilege mode. In front of the table sits a direct-mapped kernel window that builds the physical address from the virtual address itself. A physical-mode request skips translation altogether. Every result ends in a check that the address stays within the implemented physical bits, and an uncacheable flag is derived from two high address bits.

The table is filled through an insert port. New entries go into a round-robin slot. A flush-all command and a flush-by-page-and-space command remove entries. Page sizes are 8 KB, so bits 12:0 are the page offset and bits 42:13 are the virtual page number. Lookup is purely combinational from the request inputs and the stored entries. Inserts and flushes take effect at the next rising clock edge.

Top module: `itx_xlate`

## Requirements
- R1: With `req_phys` high the physical address is `req_va` itself. No canonical check, window check or table lookup is made. The only fault that can result is the machine check of R8.
- R2: With `req_phys` low, a virtual address whose bits 63:43 are not all equal to bit 42 gives fault code 1 (access violation).
- R3: With `sp_enable[1]` set, `req_va[42:41]` equal to 2'b10 and `req_mode` 0 (kernel), the table is not consulted. The address is `req_va[43:0]`. Bits 43:40 become 4'hF when bit 39 or bit 40 of that value is set, and 4'h0 otherwise. With `sp_enable[1]` clear the table path is used.
- R4: A request that falls in that window with `req_mode` other than 0 gives fault code 1.
- R5: The table hits only on a valid entry whose page number equals `req_va[42:13]` and whose space number equals `req_asn`. A miss gives fault code 2.
- R6: On a hit the physical address is `{pfn, req_va[12:2], 2'b00}`. When several entries match, the lowest-numbered slot supplies it.
- R7: On a hit, bit `req_mode` of the entry's 4-bit execute-enable field must be 1. Otherwise fault code 1 results.
- R8: A result with any bit above bit 43 set gives fault code 3 (machine check). Whenever the fault code is not 0, `xl_pa` and `xl_uncached` are 0.
- R9: With fault code 0, `xl_uncached` is 1 exactly when bit 39 or bit 40 of `xl_pa` is set.
- R10: An insert writes the slot named by a pointer. The pointer is 0 after reset, advances by one per accepted insert and wraps after slot DEPTH-1, so insert DEPTH+1 replaces the first.
- R11: `flush_all` invalidates every entry at the next edge. An insert in the same cycle is dropped and does not move the pointer.
- R12: `flush_one` invalidates only the entries whose page number equals `flush_va[42:13]` and whose space number equals `flush_asn`.
- R13: After reset every entry is invalid, so any table-path request misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_va | input | 64 | Fetch virtual address |
| req_phys | input | 1 | Request is already physical |
| req_mode | input | 2 | Current mode, 0 = kernel |
| req_asn | input | 8 | Current address space number |
| sp_enable | input | 2 | Window enable field, bit 1 active |
| xl_pa | output | 44 | Translated physical address |
| xl_uncached | output | 1 | Access is uncacheable |
| xl_fault | output | 2 | 0 none, 1 access violation, 2 miss, 3 machine check |
| ins_en | input | 1 | Insert an entry |
| ins_va | input | 64 | Virtual address giving the page number to insert |
| ins_asn | input | 8 | Space number of the new entry |
| ins_pfn | input | 32 | Page frame number of the new entry |
| ins_xre | input | 4 | Execute enable per mode |
| flush_all | input | 1 | Invalidate every entry |
| flush_one | input | 1 | Invalidate matching entries |
| flush_va | input | 64 | Address giving the page number to flush |
| flush_asn | input | 8 | Space number to flush |

## Verification
The properties assume that request inputs are steady around the sampling edge. They also assume that `flush_one` and `ins_en` are not raised together for the same page. The stimulus drives every input on the falling edge and keeps those two commands in separate cycles. The flush-empties property further assumes that no insert lands in the cycle after a flush-all. The bench holds inserts off for that cycle by probing right after each flush.

// File: rtl/itx_pkg.sv
package itx_pkg;

    localparam int VA_W       = 64;
    localparam int PA_IMPL_W  = 44;
    localparam int PAGE_W     = 13;
    localparam int VSPACE_MSB = 42;
    localparam int VPN_W      = VSPACE_MSB + 1 - PAGE_W;
    localparam int ASN_W      = 8;
    localparam int PFN_W      = 32;
    localparam int MODE_W     = 2;
    localparam int NUM_MODES  = 1 << MODE_W;
    localparam int UNC_BIT_A  = 39;
    localparam int UNC_BIT_B  = 40;
    localparam int EXT_LO     = 40;
    localparam int EXT_W      = PA_IMPL_W - EXT_LO;
    localparam int WIN_LO     = VSPACE_MSB - 1;
    localparam logic [1:0] WIN_TAG = 2'b10;
    localparam int SP_BIT     = 1;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_ACV  = 2'd1,
        FLT_MISS = 2'd2,
        FLT_MCHK = 2'd3
    } fault_e;

    localparam logic [MODE_W-1:0] MODE_KERNEL = '0;

    typedef struct packed {
        logic                 valid;
        logic [VPN_W-1:0]     vpn;
        logic [ASN_W-1:0]     asn;
        logic [PFN_W-1:0]     pfn;
        logic [NUM_MODES-1:0] xre;
    } tlb_entry_t;

    typedef struct packed {
        logic                 hit;
        tlb_entry_t           entry;
    } lookup_t;

    function automatic logic va_canonical(input logic [VA_W-1:0] va);
        logic [VA_W-1-VSPACE_MSB:0] top;
        top = va[VA_W-1:VSPACE_MSB];
        return (&top) | ~(|top);
    endfunction

    function automatic logic [VPN_W-1:0] va_vpn(input logic [VA_W-1:0] va);
        return va[VSPACE_MSB:PAGE_W];
    endfunction

    function automatic logic in_window(input logic [VA_W-1:0] va,
                                       input logic [1:0]      spen);
        return spen[SP_BIT] && (va[VSPACE_MSB:WIN_LO] == WIN_TAG);
    endfunction

endpackage

// File: rtl/itx_rr_ptr.sv
module itx_rr_ptr #(
    parameter int DEPTH = 48,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (adv) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/itx_tag_array.sv
module itx_tag_array
    import itx_pkg::*;
#(
    parameter int DEPTH = 48,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_slot,
    input  tlb_entry_t       wr_entry,
    input  logic             clr_all,
    input  logic             clr_one,
    input  logic [VPN_W-1:0] clr_vpn,
    input  logic [ASN_W-1:0] clr_asn,
    input  logic [VPN_W-1:0] look_vpn,
    input  logic [ASN_W-1:0] look_asn,
    output lookup_t          look_res
);
    tlb_entry_t       slot_vec [DEPTH];
    logic [DEPTH-1:0] match_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        tlb_entry_t slot_q;
        logic       clr_hit;

        assign clr_hit = slot_q.valid && (slot_q.vpn == clr_vpn) &&
                         (slot_q.asn == clr_asn);

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q.valid <= 1'b0;
            end else if (clr_all) begin
                slot_q.valid <= 1'b0;
            end else if (wr_en && (wr_slot == IDX_W'(g))) begin
                slot_q <= wr_entry;
            end else if (clr_one && clr_hit) begin
                slot_q.valid <= 1'b0;
            end
        end

        assign slot_vec[g]  = slot_q;
        assign match_vec[g] = slot_q.valid && (slot_q.vpn == look_vpn) &&
                              (slot_q.asn == look_asn);
    end

    always_comb begin
        look_res.hit   = |match_vec;
        look_res.entry = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                look_res.entry = slot_vec[i];
            end
        end
    end
endmodule

// File: rtl/itx_window.sv
module itx_window
    import itx_pkg::*;
(
    input  logic [VA_W-1:0]   va,
    input  logic [1:0]        spen,
    input  logic [MODE_W-1:0] mode,
    output logic              win_hit,
    output logic              win_mode_ok,
    output logic [VA_W-1:0]   win_pa
);
    logic [VA_W-1:0] masked;

    always_comb begin
        win_hit     = in_window(va, spen);
        win_mode_ok = (mode == MODE_KERNEL);
        masked      = '0;
        masked[PA_IMPL_W-1:0] = va[PA_IMPL_W-1:0];
        win_pa      = masked;
        if (masked[UNC_BIT_A] || masked[UNC_BIT_B]) begin
            win_pa[PA_IMPL_W-1:EXT_LO] = {EXT_W{1'b1}};
        end else begin
            win_pa[PA_IMPL_W-1:EXT_LO] = '0;
        end
    end
endmodule

// File: rtl/itx_xlate.sv
module itx_xlate
    import itx_pkg::*;
#(
    parameter int DEPTH = 48
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [VA_W-1:0]      req_va,
    input  logic                 req_phys,
    input  logic [MODE_W-1:0]    req_mode,
    input  logic [ASN_W-1:0]     req_asn,
    input  logic [1:0]           sp_enable,
    output logic [PA_IMPL_W-1:0] xl_pa,
    output logic                 xl_uncached,
    output logic [1:0]           xl_fault,
    input  logic                 ins_en,
    input  logic [VA_W-1:0]      ins_va,
    input  logic [ASN_W-1:0]     ins_asn,
    input  logic [PFN_W-1:0]     ins_pfn,
    input  logic [NUM_MODES-1:0] ins_xre,
    input  logic                 flush_all,
    input  logic                 flush_one,
    input  logic [VA_W-1:0]      flush_va,
    input  logic [ASN_W-1:0]     flush_asn
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             ins_take;
    logic [IDX_W-1:0] ins_slot;
    tlb_entry_t       ins_entry;
    lookup_t          look_res;
    logic             win_hit;
    logic             win_mode_ok;
    logic [VA_W-1:0]  win_pa;
    logic [VA_W-1:0]  raw_pa;
    fault_e           flt;

    assign ins_take = ins_en && !flush_all;

    always_comb begin
        ins_entry.valid = 1'b1;
        ins_entry.vpn   = va_vpn(ins_va);
        ins_entry.asn   = ins_asn;
        ins_entry.pfn   = ins_pfn;
        ins_entry.xre   = ins_xre;
    end

    itx_rr_ptr #(.DEPTH(DEPTH)) ptr_i (
        .clk (clk),
        .rst (rst),
        .adv (ins_take),
        .ptr (ins_slot)
    );

    itx_tag_array #(.DEPTH(DEPTH)) tags_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ins_take),
        .wr_slot  (ins_slot),
        .wr_entry (ins_entry),
        .clr_all  (flush_all),
        .clr_one  (flush_one),
        .clr_vpn  (va_vpn(flush_va)),
        .clr_asn  (flush_asn),
        .look_vpn (va_vpn(req_va)),
        .look_asn (req_asn),
        .look_res (look_res)
    );

    itx_window win_i (
        .va          (req_va),
        .spen        (sp_enable),
        .mode        (req_mode),
        .win_hit     (win_hit),
        .win_mode_ok (win_mode_ok),
        .win_pa      (win_pa)
    );

    always_comb begin
        raw_pa = '0;
        flt    = FLT_NONE;
        if (req_phys) begin
            raw_pa = req_va;
        end else if (!va_canonical(req_va)) begin
            flt = FLT_ACV;
        end else if (win_hit) begin
            if (win_mode_ok) begin
                raw_pa = win_pa;
            end else begin
                flt = FLT_ACV;
            end
        end else if (!look_res.hit) begin
            flt = FLT_MISS;
        end else begin
            raw_pa[PAGE_W +: PFN_W]  = look_res.entry.pfn;
            raw_pa[PAGE_W-1:2]       = req_va[PAGE_W-1:2];
            if (!look_res.entry.xre[req_mode]) begin
                flt = FLT_ACV;
            end
        end
        if ((flt == FLT_NONE) && (|raw_pa[VA_W-1:PA_IMPL_W])) begin
            flt = FLT_MCHK;
        end
    end

    assign xl_fault    = flt;
    assign xl_pa       = (flt == FLT_NONE) ? raw_pa[PA_IMPL_W-1:0] : '0;
    assign xl_uncached = (flt == FLT_NONE) &&
                         (raw_pa[UNC_BIT_A] || raw_pa[UNC_BIT_B]);
endmodule

// File: rtl/itx_checker.sv
module itx_checker
    import itx_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [VA_W-1:0]      req_va,
    input logic                 req_phys,
    input logic [MODE_W-1:0]    req_mode,
    input logic [1:0]           sp_enable,
    input logic [PA_IMPL_W-1:0] xl_pa,
    input logic                 xl_uncached,
    input logic [1:0]           xl_fault,
    input logic                 flush_all
);
    logic canon;
    logic win;

    assign canon = va_canonical(req_va);
    assign win   = in_window(req_va, sp_enable);

    AST_PHYS_ONLY_MCHK: assert property (@(posedge clk) disable iff (rst)
        req_phys |-> (xl_fault == FLT_NONE || xl_fault == FLT_MCHK)); // R1

    AST_NONCANON_ACV: assert property (@(posedge clk) disable iff (rst)
        (!req_phys && !canon) |-> (xl_fault == FLT_ACV)); // R2

    AST_WINDOW_NO_TABLE: assert property (@(posedge clk) disable iff (rst)
        (!req_phys && canon && win && req_mode == MODE_KERNEL) |-> (xl_fault == FLT_NONE)); // R3

    AST_WINDOW_USER_ACV: assert property (@(posedge clk) disable iff (rst)
        (!req_phys && canon && win && req_mode != MODE_KERNEL) |-> (xl_fault == FLT_ACV)); // R4

    AST_FAULT_ZEROES_OUT: assert property (@(posedge clk) disable iff (rst)
        (xl_fault != FLT_NONE) |-> (xl_pa == '0 && !xl_uncached)); // R8

    AST_UNCACHED_BITS: assert property (@(posedge clk) disable iff (rst)
        (xl_fault == FLT_NONE) |-> (xl_uncached == (xl_pa[UNC_BIT_A] | xl_pa[UNC_BIT_B]))); // R9

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> (req_phys || !canon || win || xl_fault == FLT_MISS)); // R11
endmodule

bind itx_xlate itx_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_va      (req_va),
    .req_phys    (req_phys),
    .req_mode    (req_mode),
    .sp_enable   (sp_enable),
    .xl_pa       (xl_pa),
    .xl_uncached (xl_uncached),
    .xl_fault    (xl_fault),
    .flush_all   (flush_all)
);

// File: tb/itx_xlate_tb_top.sv
`timescale 1ns/1ps
module itx_xlate_tb_top;
    import itx_pkg::*;

    localparam int DEPTH = 48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] req_va = '0;
    logic        req_phys = 1'b0;
    logic [1:0]  req_mode = '0;
    logic [7:0]  req_asn = '0;
    logic [1:0]  sp_enable = '0;
    logic [43:0] xl_pa;
    logic        xl_uncached;
    logic [1:0]  xl_fault;
    logic        ins_en = 1'b0;
    logic [63:0] ins_va = '0;
    logic [7:0]  ins_asn = '0;
    logic [31:0] ins_pfn = '0;
    logic [3:0]  ins_xre = '0;
    logic        flush_all = 1'b0;
    logic        flush_one = 1'b0;
    logic [63:0] flush_va = '0;
    logic [7:0]  flush_asn = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    bit          m_v   [DEPTH];
    logic [29:0] m_vpn [DEPTH];
    logic [7:0]  m_asn [DEPTH];
    logic [31:0] m_pfn [DEPTH];
    logic [3:0]  m_xre [DEPTH];
    int          m_ptr = 0;
    logic [29:0] pool  [16];

    always #2.5 clk = ~clk;

    itx_xlate #(.DEPTH(DEPTH)) dut_i (.*);

    function automatic logic [63:0] mkva(input logic [29:0] vpn, input logic [12:0] off);
        return {{21{vpn[29]}}, vpn, off};
    endfunction

    function automatic void model_xlate(input logic [63:0] va, input logic phys,
        input logic [1:0] mode, input logic [7:0] asn, input logic [1:0] spen,
        output logic [43:0] epa, output logic eunc, output logic [1:0] eflt);
        logic [63:0] p;
        logic [1:0]  f;
        int          hi;
        p = '0;
        f = 2'd0;
        if (phys) begin
            p = va;
        end else if (va[63:42] != '0 && va[63:42] != '1) begin
            f = 2'd1;
        end else if (spen[1] && va[42:41] == 2'b10) begin
            if (mode != 2'd0) f = 2'd1;
            else begin
                p = {20'h0, va[43:0]};
                p[43:40] = (p[39] || p[40]) ? 4'hF : 4'h0;
            end
        end else begin
            hi = -1;
            for (int i = DEPTH - 1; i >= 0; i--)
                if (m_v[i] && m_vpn[i] == va[42:13] && m_asn[i] == asn) hi = i;
            if (hi < 0) f = 2'd2;
            else begin
                p = (64'(m_pfn[hi]) << 13) | {51'h0, va[12:2], 2'b00};
                if (!m_xre[hi][mode]) f = 2'd1;
            end
        end
        if (f == 2'd0 && p[63:44] != '0) f = 2'd3;
        epa  = (f == 2'd0) ? p[43:0] : '0;
        eunc = (f == 2'd0) && (p[39] || p[40]);
        eflt = f;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic probe(input logic [63:0] va, input logic phys, input logic [1:0] mode,
                         input logic [7:0] asn, input logic [1:0] spen, input string tag);
        logic [43:0] epa;
        logic        eunc;
        logic [1:0]  eflt;
        @(negedge clk);
        req_va = va; req_phys = phys; req_mode = mode; req_asn = asn; sp_enable = spen;
        #1;
        model_xlate(va, phys, mode, asn, spen, epa, eunc, eflt);
        check({tag, " fault"}, 64'(xl_fault), 64'(eflt));
        check({tag, " pa"}, 64'(xl_pa), 64'(epa));
        check({tag, " uncached"}, 64'(xl_uncached), 64'(eunc));
    endtask

    task automatic do_insert(input logic [63:0] va, input logic [7:0] asn,
                             input logic [31:0] pfn, input logic [3:0] xre, input bit with_flush);
        @(negedge clk);
        ins_en = 1'b1; ins_va = va; ins_asn = asn; ins_pfn = pfn; ins_xre = xre;
        flush_all = with_flush;
        @(negedge clk);
        ins_en = 1'b0; flush_all = 1'b0;
        if (with_flush) begin
            for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
        end else begin
            m_v[m_ptr] = 1; m_vpn[m_ptr] = va[42:13]; m_asn[m_ptr] = asn;
            m_pfn[m_ptr] = pfn; m_xre[m_ptr] = xre;
            m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
        end
    endtask

    task automatic do_flush_one(input logic [63:0] va, input logic [7:0] asn);
        @(negedge clk);
        flush_one = 1'b1; flush_va = va; flush_asn = asn;
        @(negedge clk);
        flush_one = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (m_v[i] && m_vpn[i] == va[42:13] && m_asn[i] == asn) m_v[i] = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] va;
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
        for (int i = 0; i < 16; i++) pool[i] = 30'($urandom);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        probe(mkva(30'h123, 13'h0), 0, 0, 8'd0, 2'b00, "R13 reset miss");
        probe(64'h0000_0080_1234_5678, 1, 3, 8'd0, 2'b00, "R1 phys bypass");
        probe(64'h0004_0000_0000_0010, 1, 0, 8'd0, 2'b10, "R8 phys mchk");
        probe(64'h0001_0000_0000_0000, 0, 0, 8'd0, 2'b00, "R2 noncanonical");
        probe(64'hFFFF_FC80_0000_1234, 0, 0, 8'd0, 2'b10, "R3 window ext");
        probe(64'hFFFF_FC00_1234_5678, 0, 0, 8'd0, 2'b10, "R3 window plain");
        probe(64'hFFFF_FC00_1234_5678, 0, 0, 8'd0, 2'b01, "R3 window off");
        probe(64'hFFFF_FC00_1234_5678, 0, 3, 8'd0, 2'b10, "R4 window user");

        do_insert(mkva(30'h201, 13'h0), 8'd5, 32'h123, 4'b0101, 0);
        probe(mkva(30'h201, 13'h7), 0, 0, 8'd5, 2'b00, "R6 hit offset");
        probe(mkva(30'h201, 13'h7), 0, 1, 8'd5, 2'b00, "R7 mode deny");
        probe(mkva(30'h201, 13'h1FFF), 0, 2, 8'd5, 2'b00, "R7 mode allow");
        probe(mkva(30'h201, 13'h7), 0, 0, 8'd6, 2'b00, "R5 asn miss");
        probe(mkva(30'h202, 13'h7), 0, 0, 8'd5, 2'b00, "R5 vpn miss");
        do_insert(mkva(30'h300, 13'h0), 8'd1, 32'h8000_0001, 4'hF, 0);
        probe(mkva(30'h300, 13'h40), 0, 3, 8'd1, 2'b00, "R8 table mchk");
        do_insert(mkva(30'h301, 13'h0), 8'd1, 32'h0400_0000, 4'hF, 0);
        probe(mkva(30'h301, 13'h40), 0, 3, 8'd1, 2'b00, "R9 uncached");
        do_insert(mkva(30'h201, 13'h0), 8'd5, 32'h777, 4'hF, 0);
        probe(mkva(30'h201, 13'h8), 0, 0, 8'd5, 2'b00, "R6 lowest slot");
        do_flush_one(mkva(30'h201, 13'h0), 8'd5);
        probe(mkva(30'h201, 13'h8), 0, 0, 8'd5, 2'b00, "R12 flushed");
        probe(mkva(30'h301, 13'h8), 0, 0, 8'd1, 2'b00, "R12 kept");

        do_insert(mkva(30'h400, 13'h0), 8'd2, 32'h55, 4'hF, 1);
        probe(mkva(30'h400, 13'h0), 0, 0, 8'd2, 2'b00, "R11 insert dropped");
        probe(mkva(30'h301, 13'h0), 0, 0, 8'd1, 2'b00, "R11 all gone");

        for (int i = 0; i <= DEPTH; i++)
            do_insert(mkva(30'h1000 + 30'(i), 13'h0), 8'd3, 32'(i + 1), 4'hF, 0);
        probe(mkva(30'h1000, 13'h0), 0, 0, 8'd3, 2'b00, "R10 oldest replaced");
        probe(mkva(30'h1001, 13'h0), 0, 0, 8'd3, 2'b00, "R10 second kept");
        probe(mkva(30'h1000 + 30'(DEPTH), 13'h0), 0, 0, 8'd3, 2'b00, "R10 newest");

        for (int n = 0; n < 3000; n++) begin
            int op;
            op = int'($urandom % 16);
            if (op < 4) begin
                do_insert(mkva(pool[$urandom % 16], 13'h0), 8'($urandom % 4),
                          ($urandom % 8 == 0) ? 32'($urandom) : 32'($urandom % 32'h0800_0000),
                          4'($urandom), 0);
            end else if (op == 4) begin
                do_flush_one(mkva(pool[$urandom % 16], 13'h0), 8'($urandom % 4));
            end else if (op == 5 && ($urandom % 8 == 0)) begin
                do_insert(64'h0, 8'd0, 32'h0, 4'h0, 1);
            end else begin
                va = mkva(pool[$urandom % 16], 13'($urandom));
                if ($urandom % 16 == 0) va[60] = ~va[60];
                probe(va, ($urandom % 8 == 0), 2'($urandom), 8'($urandom % 4),
                      2'($urandom), "R5 R6 R7 random");
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule